// File: doc/BRIEF.md
# Time-Triggered Clock Synchronization Client

This block keeps a local notion of when each integration cycle began, so that a node on a time-triggered Ethernet network stays aligned with the network's shared time base. For every received frame it gets a strobe, the frame's destination address and ethertype, a local receive timestamp in clock cycles, and the frame's transparent-clock delay. It works out which kind of frame arrived and reports a two-bit result code. Protocol control frames also drive the clock correction.

A protocol control frame is judged by its permanence time, not by its arrival time. Permanence time is the receive stamp plus the worst-case delay, minus the dynamic delay the frame actually saw. The first such frame seeds the cycle start register. Each later frame is compared against an expected point, which lies a fixed offset after the current cycle start. A frame whose error is inside a window of plus or minus the precision nudges the cycle start through a fixed-point proportional-integral filter. A frame outside that window clears the cycle start, and the next frame then seeds it again. Three configuration inputs are taken as live values: the maximum transmission delay, the compression delay and the precision.

Top module: `tt_sync_client`

## Requirements
- R1: While reset is held and after its release, `result_valid` is 0 and `start_time` is 0 until the first frame is processed.
- R2: Frames are classified with a fixed precedence. An ethertype equal to 16'h891D is a control frame. Any other frame whose `dst_addr[47:16]` equals 32'hABADBABE is a time-triggered data frame and gets code 2. Every remaining frame gets code 3. Codes 2 and 3 leave `start_time` unchanged.
- R3: `result_valid` is a one-cycle pulse in the cycle after each `frame_done` strobe, and `result_code` is valid with it.
- R4: The dynamic delay in cycles is `(tc_value * 205) >> 11`, with `tc_value` unsigned. The permanence time is `rx_stamp + max_delay - dynamic delay`, in 32-bit wrapping arithmetic.
- R5: A control frame that arrives while no cycle start is held loads `start_time` with permanence − (2·max_delay + comp_delay). It clears the integral and returns code 1.
- R6: When a cycle start is held, the error is permanence − (start_time + 2·max_delay + comp_delay). An error in the range −precision to +precision, both ends included, is accepted. Any other error returns code 0, sets `start_time` to 0 and clears the held state, so the next control frame seeds again as in R5.
- R7: For an accepted error, the integral becomes the old integral plus the error, saturated to the signed 32-bit range. `start_time` then grows by (179·error + 77·integral) >>> 8, using an arithmetic (floor) shift, and the code is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | One-cycle strobe: the header and timing inputs hold a received frame |
| dst_addr | input | 48 | Destination address field of the frame |
| ethertype | input | 16 | Ethertype field of the frame |
| rx_stamp | input | 32 | Local receive timestamp in cycles |
| tc_value | input | 32 | Transparent-clock delay field of the frame |
| max_delay | input | 32 | Maximum transmission delay in cycles |
| comp_delay | input | 32 | Compression delay in cycles |
| precision | input | 32 | Half-width of the acceptance window in cycles |
| result_valid | output | 1 | Result strobe |
| result_code | output | 2 | 0 sync failed, 1 sync ok, 2 time-triggered data, 3 other |
| start_time | output | 32 | Current estimate of the integration-cycle start |

## Verification
Each result, and the `start_time` value that goes with it, is registered once. Both therefore appear in the cycle right after the `frame_done` strobe. The bench drives a frame on a falling edge and drops the strobe on the next falling edge, then samples code and `start_time` there, half a cycle after the capturing rising edge. A bench model that follows R4 to R7 gives the expected code and register value for each frame. The directed cases place errors exactly on both window edges and one cycle past the upper edge.

// File: rtl/tt_sync_client.sv
module tt_sync_client #(
  parameter int W = 32,
  parameter logic [15:0] PCF_ETYPE = 16'h891D,
  parameter logic [31:0] CT_MARKER = 32'hABADBABE,
  parameter int TC_MUL = 205,
  parameter int TC_SHIFT = 11,
  parameter int KP = 179,
  parameter int KI = 77,
  parameter int QF = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_done,
  input  logic [47:0]  dst_addr,
  input  logic [15:0]  ethertype,
  input  logic [W-1:0] rx_stamp,
  input  logic [W-1:0] tc_value,
  input  logic [W-1:0] max_delay,
  input  logic [W-1:0] comp_delay,
  input  logic [W-1:0] precision,
  output logic         result_valid,
  output logic [1:0]   result_code,
  output logic [W-1:0] start_time
);
  localparam int PW = 2*W + 2;
  localparam logic signed [PW-1:0] KP_X = PW'(KP);
  localparam logic signed [PW-1:0] KI_X = PW'(KI);
  localparam logic signed [W:0] SMAX = {2'b00, {(W-1){1'b1}}};
  localparam logic signed [W:0] SMIN = {2'b11, {(W-1){1'b0}}};

  logic                seeded_q;
  logic signed [W-1:0] integ_q;

  logic          is_pcf, is_tt;
  logic [2*W-1:0] tc_prod;
  logic [W-1:0]  dyn, perm, offs;
  logic signed [W-1:0] err, prec_s, integ_nx, corr;
  logic signed [W:0]   isum;
  logic signed [PW-1:0] pi;
  logic          in_win;

  assign is_pcf = (ethertype == PCF_ETYPE);
  assign is_tt  = (dst_addr[47:16] == CT_MARKER);

  assign tc_prod = {{W{1'b0}}, tc_value} * (2*W)'(TC_MUL);
  assign dyn     = W'(tc_prod >> TC_SHIFT);
  assign perm    = rx_stamp + max_delay - dyn;
  assign offs    = (max_delay << 1) + comp_delay;

  assign err    = $signed(perm - (start_time + offs));
  assign prec_s = $signed(precision);
  assign in_win = (err >= -prec_s) && (err <= prec_s);

  assign isum = (W+1)'(err) + (W+1)'(integ_q);
  always_comb begin
    if (isum > SMAX)      integ_nx = SMAX[W-1:0];
    else if (isum < SMIN) integ_nx = SMIN[W-1:0];
    else                  integ_nx = isum[W-1:0];
  end

  assign pi   = KP_X * PW'(err) + KI_X * PW'(integ_nx);
  assign corr = W'(pi >>> QF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_valid <= 1'b0;
      result_code  <= 2'd0;
      start_time   <= '0;
      seeded_q     <= 1'b0;
      integ_q      <= '0;
    end else begin
      result_valid <= frame_done;
      if (frame_done) begin
        if (!is_pcf) begin
          result_code <= is_tt ? 2'd2 : 2'd3;
        end else if (!seeded_q) begin
          start_time  <= perm - offs;
          seeded_q    <= 1'b1;
          integ_q     <= '0;
          result_code <= 2'd1;
        end else if (in_win) begin
          start_time  <= start_time + corr;
          integ_q     <= integ_nx;
          result_code <= 2'd1;
        end else begin
          start_time  <= '0;
          seeded_q    <= 1'b0;
          integ_q     <= '0;
          result_code <= 2'd0;
        end
      end
    end
  end
endmodule

// File: rtl/tt_sync_client_chk.sv
module tt_sync_client_chk #(parameter int W = 32) (
  input logic         clk,
  input logic         rst_n,
  input logic         frame_done,
  input logic         result_valid,
  input logic [1:0]   result_code,
  input logic [W-1:0] start_time
);
  // R3
  valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid == $past(frame_done));
  // R6
  fail_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && result_code == 2'd0) |-> start_time == '0);
  // R2
  data_keeps_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && result_code[1]) |-> $stable(start_time));
  // R1
  idle_keeps_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(start_time));
endmodule

bind tt_sync_client tt_sync_client_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
  .result_valid(result_valid), .result_code(result_code), .start_time(start_time)
);

// File: tb/tt_sync_client_test.sv
module tt_sync_client_test;
  logic        clk = 0, rst_n = 0, frame_done = 0;
  logic [47:0] dst_addr = '0;
  logic [15:0] ethertype = '0;
  logic [31:0] rx_stamp = '0, tc_value = '0;
  logic [31:0] max_delay = 32'd500, comp_delay = 32'd200, precision = 32'd50;
  logic        result_valid;
  logic [1:0]  result_code;
  logic [31:0] start_time;

  int checks = 0, fails = 0;
  int m_start = 0, m_integ = 0;
  bit m_seeded = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  tt_sync_client uut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic int dyn_of(input logic [31:0] tc);
    longint unsigned p = longint'(tc) * 205;
    return int'(p >> 11);
  endfunction

  function automatic int offs_of();
    return int'(max_delay) * 2 + int'(comp_delay);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // model: returns expected code and updates m_start
  task automatic model(input logic [15:0] et, input logic [47:0] da,
                       input logic [31:0] rx, input logic [31:0] tc, output int code);
    int perm, err;
    longint s, pi;
    if (et != 16'h891D) begin
      code = (da[47:16] == 32'hABADBABE) ? 2 : 3;
      return;
    end
    perm = int'(rx) + int'(max_delay) - dyn_of(tc);
    if (!m_seeded) begin
      m_start = perm - offs_of(); m_seeded = 1; m_integ = 0; code = 1;
      return;
    end
    err = perm - (m_start + offs_of());
    if (err >= -int'(precision) && err <= int'(precision)) begin
      s = longint'(m_integ) + longint'(err);
      if (s > 64'sd2147483647) s = 64'sd2147483647;
      if (s < -64'sd2147483648) s = -64'sd2147483648;
      m_integ = int'(s);
      pi = 179 * longint'(err) + 77 * longint'(m_integ);
      m_start = m_start + int'(pi >>> 8);
      code = 1;
    end else begin
      m_start = 0; m_seeded = 0; m_integ = 0; code = 0;
    end
  endtask

  task automatic send(input string req, input logic [15:0] et, input logic [47:0] da,
                      input logic [31:0] rx, input logic [31:0] tc);
    int code;
    model(et, da, rx, tc, code);
    @(negedge clk);
    ethertype = et; dst_addr = da; rx_stamp = rx; tc_value = tc; frame_done = 1;
    @(negedge clk);
    frame_done = 0;
    chk({req, " R3 valid"}, result_valid, 1);
    chk({req, " code"}, result_code, code);
    chk({req, " start_time"}, $signed(start_time), m_start);
    @(negedge clk);
    chk("R3 pulse", result_valid, 0);
  endtask

  // PCF whose error against the model is exactly e
  task automatic pcf_err(input string req, input int e, input logic [31:0] tc);
    int target = m_start + offs_of() + e;
    send(req, 16'h891D, 48'h0, 32'(target - int'(max_delay) + dyn_of(tc)), tc);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", result_valid, 0);
    chk("R1 start in reset", start_time, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 valid after reset", result_valid, 0);
    chk("R1 start after reset", start_time, 0);

    send("R2 other", 16'h0800, 48'h1234_5678_9ABC, 32'd77, 32'd0);
    send("R2 tt data", 16'h88D7, {32'hABADBABE, 16'h0042}, 32'd99, 32'd5);
    // R4 R5 first PCF seeds, tc conversion with nonzero value
    send("R5 seed", 16'h891D, {32'hABADBABE, 16'h0001}, 32'd5000, 32'd730);
    chk("R5 seed value", $signed(start_time), 5000 + 500 - ((730 * 205) >> 11) - 1200);
    // R6 window edges
    pcf_err("R6 upper edge", 50, 32'd100);
    pcf_err("R6 lower edge", -50, 32'd0);
    pcf_err("R7 small err", 7, 32'd333);
    pcf_err("R6 past edge", 51, 32'd0);
    chk("R6 cleared", start_time, 0);
    pcf_err("R6 reseed", 0, 32'd20);
    send("R2 data keeps", 16'h1111, {32'hABADBABE, 16'h7}, 32'd1, 32'd1);

    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 9);
      logic [31:0] tc = $urandom_range(0, 2000);
      if (sel < 6) begin
        int e = $urandom_range(0, 120) - 60;
        pcf_err("R7 random pcf", e, tc);
      end else if (sel < 8) begin
        send("R2 random tt", 16'($urandom), {32'hABADBABE, 16'($urandom)}, $urandom, tc);
      end else begin
        send("R2 random other", 16'h0800, {16'($urandom), 32'($urandom)}, $urandom, tc);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule